// File: doc/BRIEF.md
# Configurable LUT Memory Cell

This block is a single reconfigurable logic cell built around one 64-bit storage array. A serial configuration port fills the array one bit per clock. A mode input then chooses how the same bits are used. The cell can be one 6-input lookup table, or two 5-input lookup tables that share their inputs. It can also be a 64x1 distributed RAM, one 32-stage shift register with a variable tap, or two independent 16-stage shift registers.

Each of the two lookup outputs can pass straight through, or go through a storage element. That element acts either as a rising-edge flip-flop or as a latch that is transparent while the clock is high. The shift modes also bring out the last stage of each chain, so that several cells can be cascaded.

Top module: `lut_cell`

## Requirements
- R1: While `cfgEn` is high, each rising clock edge shifts the array up by one bit position and places `cfgDin` in bit 0. After 64 such edges, the first bit driven sits in bit 63. During loading, the unregistered lookup outputs and both chain outputs read 0, and RAM writes and shift enables are ignored.
- R2: Mode code 0, and the unused codes 5 to 7, give a single 6-input table: `lutOut[0]` is array bit `addr`, `lutOut[1]` is 0.
- R3: Mode code 1 gives two 5-input tables that share `addr[4:0]`. `lutOut[0]` is bit `addr[4:0]` and `lutOut[1]` is bit `32+addr[4:0]`. `addr[5]` is ignored.
- R4: Mode code 2 gives a 64x1 RAM. When `wrEn` is high at a rising edge, `wrData` is written to bit `addr`. The read on `lutOut[0]` is combinational from the current `addr`. In every other mode `wrEn` has no effect on the array.
- R5: Mode code 3 gives one 32-stage shift register in bits 31..0. At a rising edge with `shEn[0]` high, bits 31..0 move up by one and `shIn[0]` enters bit 0. `lutOut[0]` taps bit `addr[4:0]` and `chainOut[0]` is bit 31. Bits 63..32 are untouched, and `shEn[1]` has no effect.
- R6: Mode code 4 gives two 16-stage shift registers. The lower chain is bits 15..0, fed by `shIn[0]` and shifted by `shEn[0]`. The upper chain is bits 31..16, fed by `shIn[1]` and shifted by `shEn[1]`. The two chains are independent. `lutOut[0]` taps bit `addr[3:0]` and `lutOut[1]` taps bit `16+addr[3:0]`. `chainOut[0]` is bit 15 and `chainOut[1]` is bit 31.
- R7: With `useReg[i]` low, `lutOut[i]` follows its lookup value combinationally.
- R8: With `useReg[i]` high and `latchMode` low, `lutOut[i]` takes the lookup value present at each rising edge and holds it until the next one.
- R9: With `useReg[i]` high and `latchMode` high, `lutOut[i]` follows the lookup value while `clk` is high and holds the value it had at the falling edge while `clk` is low.
- R10: In mode codes 0, 1 and 2, both `chainOut` bits are 0.
- R11: Active-low `rstN` clears the array and every output storage element asynchronously, so all outputs read 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgEn | input | 1 | Serial configuration load enable |
| cfgDin | input | 1 | Serial configuration data |
| modeSel | input | 3 | Array mode code (0 to 4) |
| useReg | input | 2 | Per-output storage element select |
| latchMode | input | 1 | Storage element acts as a latch when high |
| addr | input | ADDR_W | Lookup inputs, RAM address, or shift tap |
| wrEn | input | 1 | RAM write enable |
| wrData | input | 1 | RAM write data |
| shEn | input | 2 | Shift enables, lower and upper chain |
| shIn | input | 2 | Shift data inputs, lower and upper chain |
| lutOut | output | 2 | Lookup outputs |
| chainOut | output | 2 | Last-stage cascade outputs |

## Verification
The bench writes a RAM cell while a load is in progress. A design that leaked writes during loading would corrupt the later table reads. It also drives `addr[5]` high in dual 5-input mode, where a design that failed to ignore it would read the wrong half. In dual 16-stage mode the chains are enabled one at a time. A design that tied the two halves together, or let `shEn[1]` act in 32-stage mode, would move the idle chain or the upper array bits. Finally, the bench changes the address while the clock is high and while it is low. A flip-flop built as a latch, or a latch built as a flip-flop, would then show a value at the wrong phase.

// File: rtl/lut_cell_pkg.sv
package lut_cell_pkg;

  typedef enum logic [2:0] {
    MODE_LUT6    = 3'd0,
    MODE_LUT5X2  = 3'd1,
    MODE_RAM     = 3'd2,
    MODE_SRL32   = 3'd3,
    MODE_SRL16X2 = 3'd4
  } cellMode_t;

  // Strobes from the control decoder to the array datapath
  typedef struct packed {
    logic      load;     // serial configuration shift this cycle
    logic      ramWr;    // single-bit RAM write this cycle
    logic      shLo;     // advance lower chain
    logic      shHi;     // advance upper chain (split mode only)
    logic      chain32;  // lower chain spans the full half array
    logic      quiet;    // force lookup and chain outputs low
    cellMode_t mode;     // decoded read mode
  } cellStrobe_t;

endpackage

// File: rtl/lut_cell_ctrl.sv
module lut_cell_ctrl
  import lut_cell_pkg::*;
(
  input  logic        rstN,
  input  logic        cfgEn,
  input  logic [2:0]  modeSel,
  input  logic        wrEn,
  input  logic [1:0]  shEn,
  output cellStrobe_t strobe
);

  cellMode_t modeDec;
  logic      running;

  always_comb begin
    unique case (modeSel)
      3'd1:    modeDec = MODE_LUT5X2;
      3'd2:    modeDec = MODE_RAM;
      3'd3:    modeDec = MODE_SRL32;
      3'd4:    modeDec = MODE_SRL16X2;
      default: modeDec = MODE_LUT6;
    endcase
  end

  assign running = rstN && !cfgEn;

  always_comb begin
    strobe.mode    = modeDec;
    strobe.quiet   = cfgEn;
    strobe.load    = rstN && cfgEn;
    strobe.ramWr   = running && wrEn && (modeDec == MODE_RAM);
    strobe.chain32 = (modeDec == MODE_SRL32);
    strobe.shLo    = running && shEn[0] &&
                     ((modeDec == MODE_SRL32) || (modeDec == MODE_SRL16X2));
    strobe.shHi    = running && shEn[1] && (modeDec == MODE_SRL16X2);
  end

endmodule

// File: rtl/lut_cell_data.sv
module lut_cell_data
  import lut_cell_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  cellStrobe_t       strobe,
  input  logic              cfgDin,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrData,
  input  logic [1:0]        shIn,
  output logic [1:0]        rawOut,
  output logic [1:0]        chainOut
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int HALF  = DEPTH / 2;
  localparam int QTR   = DEPTH / 4;

  logic [DEPTH-1:0]  mem;
  logic [ADDR_W-2:0] halfIdx;
  logic [ADDR_W-3:0] qtrIdx;

  assign halfIdx = addr[ADDR_W-2:0];
  assign qtrIdx  = addr[ADDR_W-3:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mem <= '0;
    end else if (strobe.load) begin
      mem <= {mem[DEPTH-2:0], cfgDin};
    end else begin
      if (strobe.ramWr) mem[addr] <= wrData;
      if (strobe.shLo) begin
        if (strobe.chain32) mem[HALF-1:0] <= {mem[HALF-2:0], shIn[0]};
        else                mem[QTR-1:0]  <= {mem[QTR-2:0], shIn[0]};
      end
      if (strobe.shHi) mem[HALF-1:QTR] <= {mem[HALF-2:QTR], shIn[1]};
    end
  end

  always_comb begin
    rawOut   = '0;
    chainOut = '0;
    if (!strobe.quiet) begin
      unique case (strobe.mode)
        MODE_LUT5X2: begin
          rawOut[0] = mem[{1'b0, halfIdx}];
          rawOut[1] = mem[{1'b1, halfIdx}];
        end
        MODE_SRL32: begin
          rawOut[0]   = mem[{1'b0, halfIdx}];
          chainOut[0] = mem[HALF-1];
        end
        MODE_SRL16X2: begin
          rawOut[0]   = mem[{2'b00, qtrIdx}];
          rawOut[1]   = mem[{2'b01, qtrIdx}];
          chainOut[0] = mem[QTR-1];
          chainOut[1] = mem[HALF-1];
        end
        default: rawOut[0] = mem[addr];
      endcase
    end
  end

endmodule

// File: rtl/lut_cell_outstage.sv
module lut_cell_outstage (
  input  logic clk,
  input  logic rstN,
  input  logic useReg,
  input  logic latchMode,
  input  logic rawIn,
  output logic q
);

  logic flopQ;
  logic holdQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flopQ <= 1'b0;
    else       flopQ <= rawIn;
  end

  // Value frozen at the falling edge; together with the clk-high pass
  // path below this gives high-transparent latch behaviour
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) holdQ <= 1'b0;
    else       holdQ <= rawIn;
  end

  always_comb begin
    if (!useReg)        q = rawIn;
    else if (latchMode) q = clk ? rawIn : holdQ;
    else                q = flopQ;
  end

endmodule

// File: rtl/lut_cell.sv
module lut_cell
  import lut_cell_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgEn,
  input  logic              cfgDin,
  input  logic [2:0]        modeSel,
  input  logic [1:0]        useReg,
  input  logic              latchMode,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              wrData,
  input  logic [1:0]        shEn,
  input  logic [1:0]        shIn,
  output logic [1:0]        lutOut,
  output logic [1:0]        chainOut
);

  localparam int N_OUT = 2;

  cellStrobe_t      strobe;
  logic [N_OUT-1:0] rawOut;

  lut_cell_ctrl i_ctrl (
    .rstN    (rstN),
    .cfgEn   (cfgEn),
    .modeSel (modeSel),
    .wrEn    (wrEn),
    .shEn    (shEn),
    .strobe  (strobe)
  );

  lut_cell_data #(.ADDR_W(ADDR_W)) i_data (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cfgDin   (cfgDin),
    .addr     (addr),
    .wrData   (wrData),
    .shIn     (shIn),
    .rawOut   (rawOut),
    .chainOut (chainOut)
  );

  for (genvar g = 0; g < N_OUT; g++) begin : g_out
    lut_cell_outstage i_stage (
      .clk       (clk),
      .rstN      (rstN),
      .useReg    (useReg[g]),
      .latchMode (latchMode),
      .rawIn     (rawOut[g]),
      .q         (lutOut[g])
    );
  end

endmodule

// File: rtl/lut_cell_chk.sv
module lut_cell_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgEn,
  input logic [2:0]        modeSel,
  input logic [1:0]        useReg,
  input logic [ADDR_W-1:0] addr,
  input logic              wrEn,
  input logic              wrData,
  input logic [1:0]        shEn,
  input logic [1:0]        lutOut,
  input logic [1:0]        chainOut
);

  // R1: chain outputs read low while loading
  a_r1_load_quiet: assert property (@(posedge clk) disable iff (!rstN)
    cfgEn |-> chainOut == 2'b00);

  // R2: upper lookup output unused in single-table mode
  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 3'd0 && !useReg[1]) |-> lutOut[1] == 1'b0);

  // R4: a written bit reads back at the same address one cycle later
  a_r4_write_readback: assert property (@(posedge clk) disable iff (!rstN)
    ($past(modeSel) == 3'd2 && $past(wrEn) && !$past(cfgEn) &&
     modeSel == 3'd2 && !cfgEn && addr == $past(addr) && !useReg[0])
    |-> lutOut[0] == $past(wrData));

  // R5: 32-stage chain end holds when its enable is low
  a_r5_chain_hold: assert property (@(posedge clk) disable iff (!rstN)
    ($past(modeSel) == 3'd3 && modeSel == 3'd3 && !$past(cfgEn) && !cfgEn &&
     !$past(shEn[0])) |-> chainOut[0] == $past(chainOut[0]));

  // R6: upper 16-stage chain end holds while only its own enable is low
  a_r6_hi_independent: assert property (@(posedge clk) disable iff (!rstN)
    ($past(modeSel) == 3'd4 && modeSel == 3'd4 && !$past(cfgEn) && !cfgEn &&
     !$past(shEn[1])) |-> chainOut[1] == $past(chainOut[1]));

  // R10: no cascade output outside the shift modes
  a_r10_chain_zero: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel <= 3'd2) |-> chainOut == 2'b00);

endmodule

bind lut_cell lut_cell_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cfgEn    (cfgEn),
  .modeSel  (modeSel),
  .useReg   (useReg),
  .addr     (addr),
  .wrEn     (wrEn),
  .wrData   (wrData),
  .shEn     (shEn),
  .lutOut   (lutOut),
  .chainOut (chainOut)
);

// File: tb/test_lut_cell.sv
`timescale 1ns/1ps
module test_lut_cell;

  logic       clk = 1'b0;
  logic       rstN, cfgEn, cfgDin, latchMode, wrEn, wrData;
  logic [2:0] modeSel;
  logic [1:0] useReg, shEn, shIn, lutOut, chainOut;
  logic [5:0] addr;

  always #2 clk = ~clk;

  lut_cell i_lut_cell (
    .clk(clk), .rstN(rstN), .cfgEn(cfgEn), .cfgDin(cfgDin), .modeSel(modeSel),
    .useReg(useReg), .latchMode(latchMode), .addr(addr), .wrEn(wrEn),
    .wrData(wrData), .shEn(shEn), .shIn(shIn), .lutOut(lutOut),
    .chainOut(chainOut)
  );

  int total = 0;
  int bad   = 0;
  logic [63:0] model;

  localparam logic [63:0] PAT = 64'h0F0F_0000_0000_FF01;

  // {mode, addr, expected {chain1, chain0, lut1, lut0}} after loading PAT
  localparam int NV = 18;
  localparam logic [12:0] VECS [NV] = '{
    {3'd0, 6'd0,  4'b0001}, {3'd0, 6'd5,  4'b0000}, {3'd0, 6'd9,  4'b0001},
    {3'd0, 6'd50, 4'b0001}, {3'd0, 6'd54, 4'b0000}, {3'd0, 6'd57, 4'b0001},
    {3'd1, 6'd0,  4'b0001}, {3'd1, 6'd9,  4'b0001}, {3'd1, 6'd18, 4'b0010},
    {3'd1, 6'd24, 4'b0010}, {3'd1, 6'd52, 4'b0000}, {3'd1, 6'd40, 4'b0001},
    {3'd2, 6'd57, 4'b0001}, {3'd7, 6'd50, 4'b0001}, {3'd3, 6'd8,  4'b0001},
    {3'd4, 6'd8,  4'b0101}, {3'd4, 6'd0,  4'b0101}, {3'd3, 6'd40, 4'b0001}
  };

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  function automatic logic [3:0] refOut(input logic [2:0] m, input logic [5:0] a);
    logic [3:0] r;
    r = '0;
    case (m)
      3'd1: begin r[0] = model[{1'b0, a[4:0]}]; r[1] = model[{1'b1, a[4:0]}]; end
      3'd3: begin r[0] = model[{1'b0, a[4:0]}]; r[2] = model[31]; end
      3'd4: begin
        r[0] = model[{2'b00, a[3:0]}]; r[1] = model[{2'b01, a[3:0]}];
        r[2] = model[15]; r[3] = model[31];
      end
      default: r[0] = model[a];
    endcase
    return r;
  endfunction

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    rstN = 0; cfgEn = 0; cfgDin = 0; latchMode = 0; wrEn = 0; wrData = 0;
    modeSel = 0; useReg = 2'b11; shEn = 0; shIn = 0; addr = 0;
    repeat (3) cyc();
    #1 check("R11 outputs in reset", {chainOut, lutOut}, 4'b0000);
    rstN = 1;
    cyc();
    #1 check("R11 flops cleared", {chainOut, lutOut}, 4'b0000);
    useReg = 2'b00; addr = 6'd33;
    #1 check("R11 array cleared", {chainOut, lutOut}, 4'b0000);

    // R1: serial load with RAM write and shift requests held active
    cyc();
    cfgEn = 1; modeSel = 3'd2; wrEn = 1; wrData = 1; addr = 6'd5;
    shEn = 2'b11; shIn = 2'b11;
    for (int i = 63; i >= 0; i--) begin
      cfgDin = PAT[i];
      if (i == 20) begin
        #1 check("R1 outputs quiet while loading", {chainOut, lutOut}, 4'b0000);
        modeSel = 3'd4;
        #1 check("R1 chain quiet while loading", {chainOut, lutOut}, 4'b0000);
        modeSel = 3'd2;
      end
      cyc();
    end
    cfgEn = 0; wrEn = 0; shEn = 0; shIn = 0;
    model = PAT;

    // R1/R2/R3/R4/R5/R6/R10: table walk over the loaded pattern
    for (int v = 0; v < NV; v++) begin
      modeSel = VECS[v][12:10];
      addr    = VECS[v][9:4];
      #0.2 check($sformatf("R2 R3 R5 R6 R10 table vector %0d", v),
                 {chainOut, lutOut}, VECS[v][3:0]);
    end
    cyc();

    // R4: RAM write and readback
    modeSel = 3'd2; addr = 6'd5; wrData = 1; wrEn = 1;
    cyc(); model[5] = 1'b1; wrEn = 0;
    #1 check("R4 write one readback", {chainOut, lutOut}, refOut(3'd2, 6'd5));
    addr = 6'd8; wrData = 0; wrEn = 1;
    cyc(); model[8] = 1'b0; wrEn = 0;
    #1 check("R4 write zero readback", {chainOut, lutOut}, refOut(3'd2, 6'd8));
    modeSel = 3'd0; addr = 6'd62; wrData = 1; wrEn = 1;
    cyc(); wrEn = 0; modeSel = 3'd2;
    #1 check("R4 write ignored outside RAM mode", {chainOut, lutOut}, 4'b0000);

    // R5: 32-stage shifting with irregular enable; upper enable must not act
    modeSel = 3'd3;
    for (int k = 0; k < 40; k++) begin
      addr    = 6'(k % 32);
      shIn[0] = (k % 3 == 0);
      shEn[0] = (k % 5 != 4);
      shEn[1] = 1'b1; shIn[1] = 1'b1;
      cyc();
      if (shEn[0]) model[31:0] = {model[30:0], shIn[0]};
      #1 check($sformatf("R5 shift32 step %0d", k), {chainOut, lutOut},
               refOut(3'd3, addr));
    end
    shEn = 0; shIn = 0;
    modeSel = 3'd0;
    for (int a = 0; a < 64; a++) begin
      addr = 6'(a);
      #0.2 check($sformatf("R5 array bit %0d after shift32", a),
                 {chainOut, lutOut}, refOut(3'd0, addr));
    end
    cyc();

    // R6: split chains, each on its own enable
    modeSel = 3'd4;
    for (int k = 0; k < 30; k++) begin
      addr = 6'(k % 16);
      shEn = (k < 10) ? 2'b01 : (k < 20) ? 2'b10 : 2'b11;
      shIn = {1'(k % 2), 1'(k % 3 == 0)};
      cyc();
      if (shEn[0]) model[15:0]  = {model[14:0], shIn[0]};
      if (shEn[1]) model[31:16] = {model[30:16], shIn[1]};
      #1 check($sformatf("R6 split shift step %0d", k), {chainOut, lutOut},
               refOut(3'd4, addr));
    end
    shEn = 0; shIn = 0;

    // Known bits for the storage tests: bit3=1, bit4=0, bit35=0, bit36=1
    modeSel = 3'd2; wrEn = 1;
    addr = 6'd3;  wrData = 1; cyc();
    addr = 6'd4;  wrData = 0; cyc();
    addr = 6'd35; wrData = 0; cyc();
    addr = 6'd36; wrData = 1; cyc();
    wrEn = 0;

    // R7/R8: lut0 through flip-flop, lut1 bypassed
    modeSel = 3'd1; useReg = 2'b01; latchMode = 0; addr = 6'd3;
    cyc();
    addr = 6'd4;
    #1 check("R8 flop holds until edge, R7 bypass follows", {2'b00, lutOut}, 4'b0011);
    @(posedge clk); #0.5;
    check("R8 flop updates at rising edge", {2'b00, lutOut}, 4'b0010);
    addr = 6'd3;
    #0.5 check("R8 flop ignores change while clk high", {2'b00, lutOut}, 4'b0000);

    // R9: latch behaviour on both outputs
    useReg = 2'b11; latchMode = 1;
    @(posedge clk); #0.5;
    addr = 6'd3;
    #0.5 check("R9 latch transparent while clk high", {2'b00, lutOut}, 4'b0001);
    @(negedge clk); #0.5;
    addr = 6'd4;
    #0.5 check("R9 latch holds while clk low", {2'b00, lutOut}, 4'b0001);
    @(posedge clk); #0.5;
    check("R9 latch opens at rising edge", {2'b00, lutOut}, 4'b0010);

    // R11: asynchronous reset mid-run
    cyc();
    rstN = 0;
    #1 check("R11 async reset clears outputs", {chainOut, lutOut}, 4'b0000);
    cyc();
    rstN = 1; useReg = 2'b00; modeSel = 3'd0; addr = 6'd3;
    #1 check("R11 array cleared by reset", {chainOut, lutOut}, 4'b0000);

    cyc();
    finishRun();
  end

endmodule